// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block is the issue stage of an in-order pipeline that can start two instructions per cycle. Each cycle it looks at the two oldest entries of the decode queue. It decides whether both can leave together, only the older one, or neither. It then registers the chosen instructions into two issue slots that feed execution. Any slot without an instruction carries a no-operation, so a pairing conflict costs one slot rather than the whole cycle.

Several things prevent pairing. The machine has one data-memory port, one branch unit and one long-latency (multi-cycle) unit. The younger instruction also may not depend on the older one through a register. A scoreboard of registers still awaiting a long-latency result holds back any instruction that would read or overwrite such a register. Issue is strictly in program order. The decode queue is told, in the same cycle, how many of its head entries were taken. A wrapping counter records the cycles in which exactly one slot held a no-operation.

Top module: `dual_issue_pair`

## Requirements
- R1: `take_count` (combinational) equals the number of head entries issued in the current cycle: 0, 1 or 2, and never 3. On the next clock edge, slot 0 receives the older entry (head 0) and slot 1 the younger entry (head 1), with kind, destination, destination enable and both source numbers copied unchanged.
- R2: Issue is in order. Nothing issues when head 0 is invalid or held. Head 1 never issues unless head 0 issues in the same cycle.
- R3: Kind encoding is 0 = simple ALU, 1 = memory, 2 = branch, 3 = long-latency. Two memory instructions never issue together. A memory instruction may pair with any other kind.
- R4: Two branch instructions never issue together.
- R5: Two long-latency instructions never issue together.
- R6: Head 1 does not issue alongside head 0 when either enabled source of head 1 names the enabled destination of head 0. A head 0 whose destination enable is low never blocks head 1 this way.
- R7: Head 1 does not issue alongside head 0 when both have enabled destinations that name the same register.
- R8: Issuing a long-latency instruction with an enabled destination marks that register busy from the next cycle. Other kinds mark nothing. An entry with any enabled source or enabled destination naming a busy register is held. `done_valid` with `done_reg` clears the busy mark, and the clear is seen from the following cycle.
- R9: A slot that received no instruction shows valid 0, kind 0, destination 0, destination enable 0 and sources 0.
- R10: `half_issue_count` increases by one, wrapping, after every cycle in which exactly one entry issued. Otherwise it holds its value.
- R11: While `rst_n` is low (sampled at the clock), `take_count` is 0. After the edge, both slots are no-operations, the counter is 0 and no register is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hd0_valid | input | 1 | Head 0 (older) entry present |
| hd0_kind | input | 2 | Head 0 kind (0 ALU, 1 memory, 2 branch, 3 long) |
| hd0_dst | input | REG_W | Head 0 destination register |
| hd0_dst_en | input | 1 | Head 0 writes its destination |
| hd0_src_a | input | REG_W | Head 0 first source register |
| hd0_src_a_en | input | 1 | Head 0 reads its first source |
| hd0_src_b | input | REG_W | Head 0 second source register |
| hd0_src_b_en | input | 1 | Head 0 reads its second source |
| hd1_valid | input | 1 | Head 1 (younger) entry present |
| hd1_kind | input | 2 | Head 1 kind |
| hd1_dst | input | REG_W | Head 1 destination register |
| hd1_dst_en | input | 1 | Head 1 writes its destination |
| hd1_src_a | input | REG_W | Head 1 first source register |
| hd1_src_a_en | input | 1 | Head 1 reads its first source |
| hd1_src_b | input | REG_W | Head 1 second source register |
| hd1_src_b_en | input | 1 | Head 1 reads its second source |
| done_valid | input | 1 | A long-latency result completes this cycle |
| done_reg | input | REG_W | Register whose busy mark is cleared |
| take_count | output | 2 | Head entries consumed this cycle |
| slot0_valid | output | 1 | Slot 0 holds an instruction |
| slot0_kind | output | 2 | Slot 0 kind |
| slot0_dst | output | REG_W | Slot 0 destination |
| slot0_dst_en | output | 1 | Slot 0 destination enable |
| slot0_src_a | output | REG_W | Slot 0 first source |
| slot0_src_b | output | REG_W | Slot 0 second source |
| slot1_valid | output | 1 | Slot 1 holds an instruction |
| slot1_kind | output | 2 | Slot 1 kind |
| slot1_dst | output | REG_W | Slot 1 destination |
| slot1_dst_en | output | 1 | Slot 1 destination enable |
| slot1_src_a | output | REG_W | Slot 1 first source |
| slot1_src_b | output | REG_W | Slot 1 second source |
| half_issue_count | output | PERF_W | Cycles with exactly one entry issued |

## Verification
The checker verifies every cycle that the slots never hold two memory, two branch or two long-latency instructions, and that slot 1 is never filled without slot 0. It also checks that a taken pair carries no register dependence between its members, and that the issue count, slot occupancy and counter step agree from one cycle to the next. Some behaviour is visible only in the bench's scenarios and its reference model: the scoreboard holding and later releasing instructions, the one-cycle lag of a completion clear, the copying of fields into the slots, and the reset state.

// File: rtl/dual_issue_pkg.sv
// Shared definitions for the dual-issue pairing check.
// Assumes the instruction kind arrives already decoded into two bits.
package dual_issue_pkg;

    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_MEM    = 2'd1,
        OP_BRANCH = 2'd2,
        OP_LONG   = 2'd3
    } op_kind_e;

    localparam int unsigned ISSUE_WIDTH = 2;

    // True when two kinds compete for a unit that exists only once.
    function automatic logic kinds_clash(input logic [1:0] a, input logic [1:0] b);
        return (a == b) && (a != OP_ALU);
    endfunction

endpackage

// File: rtl/dual_issue_scoreboard.sv
// Busy-register scoreboard for long-latency results.
// It holds one bit per architectural register and answers NPORT hazard
// lookups against the registered state only: a completion clear takes
// effect from the following cycle. Assumes NREG is a power of two and
// that at most one set and one clear arrive per cycle. A set wins over
// a clear of the same register.
module dual_issue_scoreboard #(
    parameter  int NREG  = 32,
    parameter  int NPORT = 2,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [REG_W-1:0]            set_reg,
    input  logic                        clr_en,
    input  logic [REG_W-1:0]            clr_reg,
    input  logic [NPORT-1:0][REG_W-1:0] look_src_a,
    input  logic [NPORT-1:0]            look_src_a_en,
    input  logic [NPORT-1:0][REG_W-1:0] look_src_b,
    input  logic [NPORT-1:0]            look_src_b_en,
    input  logic [NPORT-1:0][REG_W-1:0] look_dst,
    input  logic [NPORT-1:0]            look_dst_en,
    output logic [NPORT-1:0]            hazard
);

    logic [NREG-1:0] busy_q;
    logic [NREG-1:0] busy_d;

    // Next busy vector: clear the completed register, then apply a new mark.
    always_comb begin
        busy_d = busy_q;
        if (clr_en) busy_d[clr_reg] = 1'b0;
        if (set_en) busy_d[set_reg] = 1'b1;
    end

    // Busy state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    // One lookup port per head entry.
    for (genvar p = 0; p < NPORT; p++) begin : g_look
        assign hazard[p] = (look_src_a_en[p] & busy_q[look_src_a[p]])
                         | (look_src_b_en[p] & busy_q[look_src_b[p]])
                         | (look_dst_en[p]   & busy_q[look_dst[p]]);
    end

endmodule

// File: rtl/dual_issue_pair_rules.sv
// Pairing decision for the two queue-head entries.
// The older entry issues when it is present and free of scoreboard
// hazards. The younger one issues only with it, and only when no unit
// is claimed twice and no register dependence links the pair.
// Purely combinational.
module dual_issue_pair_rules
    import dual_issue_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             enable,
    input  logic             old_valid,
    input  logic [1:0]       old_kind,
    input  logic [REG_W-1:0] old_dst,
    input  logic             old_dst_en,
    input  logic             old_hazard,
    input  logic             yng_valid,
    input  logic [1:0]       yng_kind,
    input  logic [REG_W-1:0] yng_dst,
    input  logic             yng_dst_en,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic             yng_src_a_en,
    input  logic [REG_W-1:0] yng_src_b,
    input  logic             yng_src_b_en,
    input  logic             yng_hazard,
    output logic [ISSUE_WIDTH-1:0] go
);

    logic unit_clash;
    logic raw_link;
    logic waw_link;
    logic old_go;

    // Structural conflict: both entries need the single memory, branch or long unit.
    always_comb unit_clash = kinds_clash(old_kind, yng_kind);

    // Younger entry reads what the older entry writes.
    always_comb raw_link = old_dst_en &&
                           ((yng_src_a_en && (yng_src_a == old_dst)) ||
                            (yng_src_b_en && (yng_src_b == old_dst)));

    // Both entries write the same register.
    always_comb waw_link = old_dst_en && yng_dst_en && (yng_dst == old_dst);

    // Older entry decision.
    always_comb old_go = enable && old_valid && !old_hazard;

    // Issue vector; the younger bit can only be set with the older one.
    always_comb begin
        go[0] = old_go;
        go[1] = old_go && yng_valid && !yng_hazard &&
                !unit_clash && !raw_link && !waw_link;
    end

endmodule

// File: rtl/dual_issue_slot.sv
// One issue-slot register. Captures an instruction when load is high,
// otherwise captures a no-operation with every field at zero.
module dual_issue_slot #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       in_kind,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_dst_en,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [REG_W-1:0] out_dst,
    output logic             out_dst_en,
    output logic [REG_W-1:0] out_src_a,
    output logic [REG_W-1:0] out_src_b
);

    // Slot register: instruction or no-operation each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !load) begin
            out_valid  <= 1'b0;
            out_kind   <= 2'd0;
            out_dst    <= '0;
            out_dst_en <= 1'b0;
            out_src_a  <= '0;
            out_src_b  <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_kind   <= in_kind;
            out_dst    <= in_dst;
            out_dst_en <= in_dst_en;
            out_src_a  <= in_src_a;
            out_src_b  <= in_src_b;
        end
    end

endmodule

// File: rtl/dual_issue_perf_count.sv
// Wrapping event counter, cleared by synchronous reset.
module dual_issue_perf_count #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [WIDTH-1:0] count
);

    // Count one per cycle with bump high.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + 1'b1;
    end

endmodule

// File: rtl/dual_issue_pair.sv
// Dual-issue pairing check: top level.
// Takes the two decode-queue head entries and reports how many were
// consumed (combinationally, same cycle). It registers the issued
// entries into two slots, filling an empty slot with a no-operation,
// and tracks long-latency destinations in a scoreboard. Assumes head 1
// is meaningful only alongside head 0, and that done_reg names a
// register previously marked by a long-latency issue.
module dual_issue_pair
    import dual_issue_pkg::*;
#(
    parameter  int NREG   = 32,
    parameter  int PERF_W = 16,
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd0_valid,
    input  logic [1:0]        hd0_kind,
    input  logic [REG_W-1:0]  hd0_dst,
    input  logic              hd0_dst_en,
    input  logic [REG_W-1:0]  hd0_src_a,
    input  logic              hd0_src_a_en,
    input  logic [REG_W-1:0]  hd0_src_b,
    input  logic              hd0_src_b_en,
    input  logic              hd1_valid,
    input  logic [1:0]        hd1_kind,
    input  logic [REG_W-1:0]  hd1_dst,
    input  logic              hd1_dst_en,
    input  logic [REG_W-1:0]  hd1_src_a,
    input  logic              hd1_src_a_en,
    input  logic [REG_W-1:0]  hd1_src_b,
    input  logic              hd1_src_b_en,
    input  logic              done_valid,
    input  logic [REG_W-1:0]  done_reg,
    output logic [1:0]        take_count,
    output logic              slot0_valid,
    output logic [1:0]        slot0_kind,
    output logic [REG_W-1:0]  slot0_dst,
    output logic              slot0_dst_en,
    output logic [REG_W-1:0]  slot0_src_a,
    output logic [REG_W-1:0]  slot0_src_b,
    output logic              slot1_valid,
    output logic [1:0]        slot1_kind,
    output logic [REG_W-1:0]  slot1_dst,
    output logic              slot1_dst_en,
    output logic [REG_W-1:0]  slot1_src_a,
    output logic [REG_W-1:0]  slot1_src_b,
    output logic [PERF_W-1:0] half_issue_count
);

    localparam int W = ISSUE_WIDTH;

    logic [W-1:0][1:0]       h_kind;
    logic [W-1:0][REG_W-1:0] h_dst;
    logic [W-1:0]            h_dst_en;
    logic [W-1:0][REG_W-1:0] h_src_a;
    logic [W-1:0]            h_src_a_en;
    logic [W-1:0][REG_W-1:0] h_src_b;
    logic [W-1:0]            h_src_b_en;
    logic [W-1:0]            hazard;
    logic [W-1:0]            go;
    logic [W-1:0]            marks;
    logic                    sb_set_en;
    logic [REG_W-1:0]        sb_set_reg;

    logic [W-1:0]            s_valid;
    logic [W-1:0][1:0]       s_kind;
    logic [W-1:0][REG_W-1:0] s_dst;
    logic [W-1:0]            s_dst_en;
    logic [W-1:0][REG_W-1:0] s_src_a;
    logic [W-1:0][REG_W-1:0] s_src_b;

    // Gather the head fields into per-entry arrays (index 0 is older).
    always_comb begin
        h_kind     = {hd1_kind,     hd0_kind};
        h_dst      = {hd1_dst,      hd0_dst};
        h_dst_en   = {hd1_dst_en,   hd0_dst_en};
        h_src_a    = {hd1_src_a,    hd0_src_a};
        h_src_a_en = {hd1_src_a_en, hd0_src_a_en};
        h_src_b    = {hd1_src_b,    hd0_src_b};
        h_src_b_en = {hd1_src_b_en, hd0_src_b_en};
    end

    dual_issue_scoreboard #(.NREG(NREG), .NPORT(W)) u_board (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (sb_set_en),
        .set_reg       (sb_set_reg),
        .clr_en        (done_valid),
        .clr_reg       (done_reg),
        .look_src_a    (h_src_a),
        .look_src_a_en (h_src_a_en),
        .look_src_b    (h_src_b),
        .look_src_b_en (h_src_b_en),
        .look_dst      (h_dst),
        .look_dst_en   (h_dst_en),
        .hazard        (hazard)
    );

    dual_issue_pair_rules #(.REG_W(REG_W)) u_rules (
        .enable       (rst_n),
        .old_valid    (hd0_valid),
        .old_kind     (hd0_kind),
        .old_dst      (hd0_dst),
        .old_dst_en   (hd0_dst_en),
        .old_hazard   (hazard[0]),
        .yng_valid    (hd1_valid),
        .yng_kind     (hd1_kind),
        .yng_dst      (hd1_dst),
        .yng_dst_en   (hd1_dst_en),
        .yng_src_a    (hd1_src_a),
        .yng_src_a_en (hd1_src_a_en),
        .yng_src_b    (hd1_src_b),
        .yng_src_b_en (hd1_src_b_en),
        .yng_hazard   (hazard[1]),
        .go           (go)
    );

    // Consumed-entry count; the rules never set the younger bit alone.
    always_comb take_count = {go[1], go[0] & ~go[1]};

    // Which issued entries write a long-latency destination.
    for (genvar i = 0; i < W; i++) begin : g_mark
        assign marks[i] = go[i] && (h_kind[i] == OP_LONG) && h_dst_en[i];
    end

    // At most one long-latency entry issues per cycle, so one set port suffices.
    always_comb begin
        sb_set_en  = |marks;
        sb_set_reg = marks[0] ? h_dst[0] : h_dst[1];
    end

    // The two issue-slot registers.
    for (genvar i = 0; i < W; i++) begin : g_slot
        dual_issue_slot #(.REG_W(REG_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (go[i]),
            .in_kind    (h_kind[i]),
            .in_dst     (h_dst[i]),
            .in_dst_en  (h_dst_en[i]),
            .in_src_a   (h_src_a[i]),
            .in_src_b   (h_src_b[i]),
            .out_valid  (s_valid[i]),
            .out_kind   (s_kind[i]),
            .out_dst    (s_dst[i]),
            .out_dst_en (s_dst_en[i]),
            .out_src_a  (s_src_a[i]),
            .out_src_b  (s_src_b[i])
        );
    end

    // Cycles that issued exactly one entry.
    dual_issue_perf_count #(.WIDTH(PERF_W)) u_perf (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (go[0] & ~go[1]),
        .count (half_issue_count)
    );

    // Drive the slot ports from the slot arrays.
    always_comb begin
        slot0_valid  = s_valid[0];
        slot0_kind   = s_kind[0];
        slot0_dst    = s_dst[0];
        slot0_dst_en = s_dst_en[0];
        slot0_src_a  = s_src_a[0];
        slot0_src_b  = s_src_b[0];
        slot1_valid  = s_valid[1];
        slot1_kind   = s_kind[1];
        slot1_dst    = s_dst[1];
        slot1_dst_en = s_dst_en[1];
        slot1_src_a  = s_src_a[1];
        slot1_src_b  = s_src_b[1];
    end

endmodule

// File: rtl/dual_issue_pair_checker.sv
// Property checker for dual_issue_pair, attached with bind.
// It observes only the top-level ports.
module dual_issue_pair_checker
    import dual_issue_pkg::*;
#(
    parameter  int NREG   = 32,
    parameter  int PERF_W = 16,
    localparam int REG_W  = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hd0_valid,
    input logic [REG_W-1:0]  hd0_dst,
    input logic              hd0_dst_en,
    input logic [REG_W-1:0]  hd1_dst,
    input logic              hd1_dst_en,
    input logic [REG_W-1:0]  hd1_src_a,
    input logic              hd1_src_a_en,
    input logic [REG_W-1:0]  hd1_src_b,
    input logic              hd1_src_b_en,
    input logic [1:0]        take_count,
    input logic              slot0_valid,
    input logic [1:0]        slot0_kind,
    input logic [REG_W-1:0]  slot0_dst,
    input logic              slot0_dst_en,
    input logic              slot1_valid,
    input logic [1:0]        slot1_kind,
    input logic [REG_W-1:0]  slot1_dst,
    input logic              slot1_dst_en,
    input logic [PERF_W-1:0] half_issue_count
);

    assert_take_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_count != 2'd3);

    assert_take_fills_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, slot0_valid} + {1'b0, slot1_valid}) == $past(take_count));

    assert_younger_needs_older_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_valid |-> slot0_valid);

    assert_empty_head_takes_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hd0_valid |-> take_count == 2'd0);

    assert_no_mem_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot0_valid && slot1_valid && slot0_kind == OP_MEM && slot1_kind == OP_MEM));

    assert_no_branch_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot0_valid && slot1_valid && slot0_kind == OP_BRANCH && slot1_kind == OP_BRANCH));

    assert_no_long_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot0_valid && slot1_valid && slot0_kind == OP_LONG && slot1_kind == OP_LONG));

    assert_no_raw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_count == 2'd2 |-> !(hd0_dst_en &&
            ((hd1_src_a_en && hd1_src_a == hd0_dst) || (hd1_src_b_en && hd1_src_b == hd0_dst))));

    assert_no_waw_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_count == 2'd2 |-> !(hd0_dst_en && hd1_dst_en && hd1_dst == hd0_dst));

    assert_nop_slot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_valid |-> (slot0_kind == 2'd0 && !slot0_dst_en && slot0_dst == '0));

    assert_nop_slot1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot1_valid |-> (slot1_kind == 2'd0 && !slot1_dst_en && slot1_dst == '0));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_count == 2'd1 |=> half_issue_count == PERF_W'($past(half_issue_count) + 1'b1));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_count != 2'd1 |=> $stable(half_issue_count));

endmodule

bind dual_issue_pair dual_issue_pair_checker #(.NREG(NREG), .PERF_W(PERF_W)) u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .hd0_valid        (hd0_valid),
    .hd0_dst          (hd0_dst),
    .hd0_dst_en       (hd0_dst_en),
    .hd1_dst          (hd1_dst),
    .hd1_dst_en       (hd1_dst_en),
    .hd1_src_a        (hd1_src_a),
    .hd1_src_a_en     (hd1_src_a_en),
    .hd1_src_b        (hd1_src_b),
    .hd1_src_b_en     (hd1_src_b_en),
    .take_count       (take_count),
    .slot0_valid      (slot0_valid),
    .slot0_kind       (slot0_kind),
    .slot0_dst        (slot0_dst),
    .slot0_dst_en     (slot0_dst_en),
    .slot1_valid      (slot1_valid),
    .slot1_kind       (slot1_kind),
    .slot1_dst        (slot1_dst),
    .slot1_dst_en     (slot1_dst_en),
    .half_issue_count (half_issue_count)
);

// File: tb/dual_issue_pair_test.sv
// Bench for dual_issue_pair: directed corner cases followed by seeded
// random traffic, each compared with an independent reference model.
module dual_issue_pair_test;

    localparam int NREG   = 32;
    localparam int PERF_W = 16;
    localparam int REG_W  = $clog2(NREG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic             hd0_valid = 0, hd1_valid = 0;
    logic [1:0]       hd0_kind = 0, hd1_kind = 0;
    logic [REG_W-1:0] hd0_dst = 0, hd1_dst = 0, hd0_src_a = 0, hd1_src_a = 0, hd0_src_b = 0, hd1_src_b = 0;
    logic             hd0_dst_en = 0, hd1_dst_en = 0, hd0_src_a_en = 0, hd1_src_a_en = 0;
    logic             hd0_src_b_en = 0, hd1_src_b_en = 0;
    logic             done_valid = 0;
    logic [REG_W-1:0] done_reg = 0;
    logic [1:0]       take_count;
    logic             slot0_valid, slot1_valid, slot0_dst_en, slot1_dst_en;
    logic [1:0]       slot0_kind, slot1_kind;
    logic [REG_W-1:0] slot0_dst, slot1_dst, slot0_src_a, slot1_src_a, slot0_src_b, slot1_src_b;
    logic [PERF_W-1:0] half_issue_count;

    int checks = 0;
    int errors = 0;
    logic [NREG-1:0]   busy_m = '0;
    logic [PERF_W-1:0] perf_m = '0;

    always #10 clk = ~clk;

    dual_issue_pair #(.NREG(NREG), .PERF_W(PERF_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .hd0_valid(hd0_valid), .hd0_kind(hd0_kind), .hd0_dst(hd0_dst), .hd0_dst_en(hd0_dst_en),
        .hd0_src_a(hd0_src_a), .hd0_src_a_en(hd0_src_a_en), .hd0_src_b(hd0_src_b), .hd0_src_b_en(hd0_src_b_en),
        .hd1_valid(hd1_valid), .hd1_kind(hd1_kind), .hd1_dst(hd1_dst), .hd1_dst_en(hd1_dst_en),
        .hd1_src_a(hd1_src_a), .hd1_src_a_en(hd1_src_a_en), .hd1_src_b(hd1_src_b), .hd1_src_b_en(hd1_src_b_en),
        .done_valid(done_valid), .done_reg(done_reg), .take_count(take_count),
        .slot0_valid(slot0_valid), .slot0_kind(slot0_kind), .slot0_dst(slot0_dst), .slot0_dst_en(slot0_dst_en),
        .slot0_src_a(slot0_src_a), .slot0_src_b(slot0_src_b),
        .slot1_valid(slot1_valid), .slot1_kind(slot1_kind), .slot1_dst(slot1_dst), .slot1_dst_en(slot1_dst_en),
        .slot1_src_a(slot1_src_a), .slot1_src_b(slot1_src_b),
        .half_issue_count(half_issue_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model: an entry is blocked by any enabled register that is busy.
    function automatic logic busy_hit(input logic [REG_W-1:0] a, input logic ae,
                                      input logic [REG_W-1:0] b, input logic be,
                                      input logic [REG_W-1:0] d, input logic de);
        return (ae && busy_m[a]) || (be && busy_m[b]) || (de && busy_m[d]);
    endfunction

    // Model: expected number of entries taken this cycle.
    function automatic int expect_take();
        logic ok1;
        if (!rst_n || !hd0_valid ||
            busy_hit(hd0_src_a, hd0_src_a_en, hd0_src_b, hd0_src_b_en, hd0_dst, hd0_dst_en))
            return 0;
        ok1 = hd1_valid &&
              !busy_hit(hd1_src_a, hd1_src_a_en, hd1_src_b, hd1_src_b_en, hd1_dst, hd1_dst_en) &&
              !(hd0_kind == hd1_kind && hd0_kind != 2'd0) &&
              !(hd0_dst_en && ((hd1_src_a_en && hd1_src_a == hd0_dst) ||
                               (hd1_src_b_en && hd1_src_b == hd0_dst))) &&
              !(hd0_dst_en && hd1_dst_en && hd1_dst == hd0_dst);
        return ok1 ? 2 : 1;
    endfunction

    task automatic put(input int idx, input logic v, input logic [1:0] k,
                       input int d, input logic de, input int a, input logic ae,
                       input int b, input logic be);
        if (idx == 0) begin
            hd0_valid = v; hd0_kind = k; hd0_dst = REG_W'(d); hd0_dst_en = de;
            hd0_src_a = REG_W'(a); hd0_src_a_en = ae; hd0_src_b = REG_W'(b); hd0_src_b_en = be;
        end else begin
            hd1_valid = v; hd1_kind = k; hd1_dst = REG_W'(d); hd1_dst_en = de;
            hd1_src_a = REG_W'(a); hd1_src_a_en = ae; hd1_src_b = REG_W'(b); hd1_src_b_en = be;
        end
    endtask

    // Called just after a falling edge with inputs driven; returns after the rising edge.
    task automatic run_cycle(input string tag, input int want);
        int et;
        logic [2*REG_W+REG_W+3:0] nop;
        nop = '0;
        #2;
        et = expect_take();
        if (want >= 0) chk({tag, " directed take"}, 64'(et), 64'(want));
        chk({tag, " R1 take_count"}, 64'(take_count), 64'(et));
        @(posedge clk);
        #3;
        if (et >= 1)
            chk({tag, " R1 slot0 fields"},
                {slot0_valid, slot0_kind, slot0_dst, slot0_dst_en, slot0_src_a, slot0_src_b},
                {1'b1, hd0_kind, hd0_dst, hd0_dst_en, hd0_src_a, hd0_src_b});
        else
            chk({tag, " R9 slot0 nop"},
                {slot0_valid, slot0_kind, slot0_dst, slot0_dst_en, slot0_src_a, slot0_src_b}, 64'(nop));
        if (et == 2)
            chk({tag, " R1 slot1 fields"},
                {slot1_valid, slot1_kind, slot1_dst, slot1_dst_en, slot1_src_a, slot1_src_b},
                {1'b1, hd1_kind, hd1_dst, hd1_dst_en, hd1_src_a, hd1_src_b});
        else
            chk({tag, " R9 slot1 nop"},
                {slot1_valid, slot1_kind, slot1_dst, slot1_dst_en, slot1_src_a, slot1_src_b}, 64'(nop));
        if (et == 1) perf_m = perf_m + 1'b1;
        chk({tag, " R10 half_issue_count"}, 64'(half_issue_count), 64'(perf_m));
        if (done_valid) busy_m[done_reg] = 1'b0;
        if (et >= 1 && hd0_kind == 2'd3 && hd0_dst_en) busy_m[hd0_dst] = 1'b1;
        if (et == 2 && hd1_kind == 2'd3 && hd1_dst_en) busy_m[hd1_dst] = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1D5E_0042));
        // R11: reset dominates even with both heads valid.
        put(0, 1, 2'd0, 1, 1, 2, 1, 3, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        chk("R11 take_count in reset", 64'(take_count), 64'd0);
        @(posedge clk);
        #3;
        chk("R11 slot0 nop after reset", 64'(slot0_valid), 64'd0);
        chk("R11 slot1 nop after reset", 64'(slot1_valid), 64'd0);
        chk("R11 counter after reset", 64'(half_issue_count), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: two independent ALU entries pair.
        put(0, 1, 2'd0, 1, 1, 2, 1, 3, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        run_cycle("R1 alu+alu", 2);
        // R3: two memory entries split.
        @(negedge clk);
        put(0, 1, 2'd1, 1, 1, 2, 1, 3, 0);
        put(1, 1, 2'd1, 4, 1, 5, 1, 6, 0);
        run_cycle("R3 mem+mem", 1);
        // R3 boundary: memory beside branch pairs.
        @(negedge clk);
        put(0, 1, 2'd1, 1, 1, 2, 1, 3, 0);
        put(1, 1, 2'd2, 0, 0, 5, 1, 6, 1);
        run_cycle("R3 mem+branch", 2);
        // R4: two branches split.
        @(negedge clk);
        put(0, 1, 2'd2, 0, 0, 2, 1, 3, 1);
        put(1, 1, 2'd2, 0, 0, 5, 1, 6, 1);
        run_cycle("R4 branch+branch", 1);
        // R5: two long-latency entries split; r7 becomes busy.
        @(negedge clk);
        put(0, 1, 2'd3, 7, 1, 2, 1, 3, 1);
        put(1, 1, 2'd3, 6, 1, 5, 1, 4, 1);
        run_cycle("R5 long+long", 1);
        // R8 and R2: head 0 reads busy r7, so nothing issues though head 1 is free.
        @(negedge clk);
        put(0, 1, 2'd0, 1, 1, 7, 1, 3, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        run_cycle("R8 R2 busy source holds both", 0);
        // R8: completion clear is not visible in its own cycle.
        @(negedge clk);
        done_valid = 1'b1; done_reg = 5'd7;
        run_cycle("R8 clear same cycle", 0);
        @(negedge clk);
        done_valid = 1'b0;
        run_cycle("R8 clear next cycle", 2);
        // R6: younger reads older destination.
        @(negedge clk);
        put(0, 1, 2'd0, 3, 1, 1, 1, 2, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 3, 1);
        run_cycle("R6 raw in pair", 1);
        // R6 boundary: older does not write, so no link.
        @(negedge clk);
        hd0_dst_en = 1'b0;
        run_cycle("R6 raw without write", 2);
        // R7: both write r2.
        @(negedge clk);
        put(0, 1, 2'd0, 2, 1, 1, 1, 3, 1);
        put(1, 1, 2'd0, 2, 1, 4, 1, 5, 1);
        run_cycle("R7 waw in pair", 1);
        // R2: head 0 empty, head 1 present.
        @(negedge clk);
        put(0, 0, 2'd0, 1, 1, 2, 1, 3, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        run_cycle("R2 empty older", 0);
        // R8: a long entry paired with an ALU marks r9; a later write to r9 waits.
        @(negedge clk);
        put(0, 1, 2'd3, 9, 1, 1, 1, 2, 1);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        run_cycle("R8 long marks", 2);
        @(negedge clk);
        put(0, 1, 2'd0, 10, 1, 11, 1, 12, 1);
        put(1, 1, 2'd0, 9, 1, 5, 0, 6, 0);
        run_cycle("R8 younger busy destination", 1);
        @(negedge clk);
        put(0, 1, 2'd0, 9, 1, 1, 0, 2, 0);
        put(1, 1, 2'd0, 4, 1, 5, 1, 6, 1);
        done_valid = 1'b1; done_reg = 5'd9;
        run_cycle("R8 older busy destination", 0);
        @(negedge clk);
        done_valid = 1'b0;
        run_cycle("R8 released", 2);
        // R8: an ALU entry marks nothing.
        @(negedge clk);
        put(0, 1, 2'd0, 13, 1, 1, 1, 2, 1);
        put(1, 1, 2'd1, 14, 1, 5, 1, 6, 1);
        run_cycle("R8 alu no mark", 2);
        @(negedge clk);
        put(0, 1, 2'd0, 15, 1, 13, 1, 14, 1);
        put(1, 1, 2'd2, 0, 0, 13, 1, 14, 1);
        run_cycle("R8 alu no mark follow", 2);

        // Random traffic over a small register range to provoke conflicts.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            for (int i = 0; i < 2; i++)
                put(i, ($urandom % 10) != 0, 2'($urandom % 4), int'($urandom % 8), 1'($urandom % 2),
                    int'($urandom % 8), 1'($urandom % 2), int'($urandom % 8), 1'($urandom % 2));
            done_valid = ($urandom % 3) == 0;
            done_reg   = REG_W'($urandom % 8);
            run_cycle("random", -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule